// File: doc/BRIEF.md
# Local Failure Monitor with Transmitter Gating

This block watches the digital side of a bus transceiver for four local fault conditions and reports them on one failure flag. Three of them are latched per source and also remove the transmitter enable: a transmit input held dominant too long, a transmit-to-receive short, and an overtemperature indication. The fourth, a bus held dominant too long, only raises the flag while it lasts. It never gates the transmitter.

Detection runs only in the two active modes, Normal and Listen-only. The latched sources are cleared together, and only when every cause has gone away. A clear happens on entry to Normal mode, or when receive reads dominant while transmit is recessive and the bus itself is dominant. The controller polls the flag in Listen-only mode. The transmitter enable is high only in Normal mode with no latched fault. Each timeout is a parameter in clock cycles. The transmit-dominant timeout is chosen so that 40 kbit/s is the slowest bit rate that still works.

Top module: `local_fail_mon`

## Requirements
- R1: A synchronous active-high reset clears all fault state, so that `lf_flag` is 0 and `tx_en` is 0 while `mode` is not Normal.
- R2: In an active mode, `txd` low (dominant) for TXD_TO consecutive clock edges latches a fault. On the following cycle `lf_flag` is 1 and `tx_en` is 0, and this holds after `txd` returns high.
- R3: In an active mode, `txd` high, `rxd` low (dominant) and `bus_dom` low for SHORT_TO consecutive edges latches a short fault. This raises `lf_flag` and forces `tx_en` low until a clear.
- R4: In an active mode, `bus_dom` high for BUS_TO consecutive edges raises `lf_flag` and leaves `tx_en` unchanged. The first edge with `bus_dom` low drops this contribution.
- R5: In an active mode, `over_temp` high at an edge latches a fault. From the next cycle `lf_flag` is 1 and `tx_en` is 0.
- R6: Entering Normal mode (from any other mode) clears all latched faults when the causes are resolved. Resolved means: `over_temp` is 0, `txd` is 1, `rxd` is not dominant while the bus is recessive, and no bus-dominant fault is live.
- R7: In an active mode, `rxd` low with `txd` high and `bus_dom` high clears all latched faults under the same resolution condition.
- R8: While a cause is unresolved, for example `over_temp` is still 1, neither clear event removes the latched faults.
- R9: In Standby (`mode`=00) and Sleep (`mode`=11) no fault is detected, the timers restart, and the latched faults hold their value.
- R10: `tx_en` is 1 only in Normal mode (`mode`=01) with no latched fault. In Listen-only mode (`mode`=10) it is always 0.
- R11: A run of dominant `txd`, or of the short condition, that ends before its timeout latches nothing. The next run counts from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| mode | input | 2 | 00 Standby, 01 Normal, 10 Listen-only, 11 Sleep |
| txd | input | 1 | Transmit data, 0 = dominant |
| rxd | input | 1 | Receive data, 0 = dominant |
| bus_dom | input | 1 | Bus state, 1 = bus dominant |
| over_temp | input | 1 | Overtemperature indication |
| lf_flag | output | 1 | Local failure flag |
| tx_en | output | 1 | Transmitter enable |

## Verification
The hardest situation to reach is a clear through the receive/transmit condition. That condition also looks like a short symptom, so it only clears when the bus is dominant, yet it must be shorter than the bus-dominant timeout. The stimulus first latches a short fault. It then raises `bus_dom` together with dominant `rxd` for a single cycle, and afterwards keeps the bus dominant past its timeout to show that a live bus fault blocks clearing. A long random phase with biased inputs then drives mode changes, short pulses and timeouts. On every clock it compares against a behavioural model built from integer run counters.

// File: rtl/lfm_pkg.sv
package lfm_pkg;

    typedef enum logic [1:0] {
        MODE_STBY   = 2'b00,
        MODE_NORM   = 2'b01,
        MODE_LISTEN = 2'b10,
        MODE_SLEEP  = 2'b11
    } lfm_mode_e;

    // One bit per latched fault source
    typedef struct packed {
        logic txd_stuck;
        logic tx_rx_short;
        logic hot;
    } lfm_fault_t;

    localparam int NUM_LATCHED = $bits(lfm_fault_t);

    function automatic logic mode_active(lfm_mode_e m);
        return (m == MODE_NORM) || (m == MODE_LISTEN);
    endfunction

    function automatic logic any_fault(lfm_fault_t f);
        return |f;
    endfunction

endpackage

// File: rtl/lfm_run_timer.sv
module lfm_run_timer #(
    parameter int LEN = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic hit
);
    localparam int CW = (LEN > 1) ? $clog2(LEN) : 1;
    localparam logic [CW-1:0] LAST = CW'(LEN - 1);

    logic [CW-1:0] cnt;

    // Counts consecutive cycles of run, saturating at LEN-1
    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (cnt != LAST) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign hit = run && (cnt == LAST);

    // R2
    hit_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (run && hit) ##1 run |-> hit);

    // R11
    restart_chk: assert property (@(posedge clk) disable iff (rst)
        !run |=> !(run && hit) || (LEN == 1));

endmodule

// File: rtl/lfm_fault_latch.sv
module lfm_fault_latch
    import lfm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  lfm_fault_t set,
    input  logic       clr,
    output lfm_fault_t lat
);
    always_ff @(posedge clk) begin
        if (rst) begin
            lat <= '0;
        end else begin
            lat <= (clr ? lfm_fault_t'('0) : lat) | set;
        end
    end

    // R8
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !clr |=> ((lat & $past(lat)) == $past(lat)));

endmodule

// File: rtl/local_fail_mon.sv
module local_fail_mon
    import lfm_pkg::*;
#(
    parameter int TXD_TO   = 64,
    parameter int SHORT_TO = 16,
    parameter int BUS_TO   = 128
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] mode,
    input  logic       txd,
    input  logic       rxd,
    input  logic       bus_dom,
    input  logic       over_temp,
    output logic       lf_flag,
    output logic       tx_en
);
    lfm_mode_e  mode_e;
    logic       active;
    logic       txd_run, short_run, bus_run;
    logic       txd_hit, short_hit, bus_hit;
    logic       bus_live;
    logic       was_norm;
    logic       enter_norm, rx_tx_event, resolved, clr;
    lfm_fault_t set_v, lat;

    assign mode_e = lfm_mode_e'(mode);
    assign active = mode_active(mode_e);

    // Detection conditions, qualified by mode
    assign txd_run   = active && !txd;
    assign short_run = active && txd && !rxd && !bus_dom;
    assign bus_run   = active && bus_dom;

    lfm_run_timer #(.LEN(TXD_TO))   u_txd_tmr   (.clk(clk), .rst(rst), .run(txd_run),   .hit(txd_hit));
    lfm_run_timer #(.LEN(SHORT_TO)) u_short_tmr (.clk(clk), .rst(rst), .run(short_run), .hit(short_hit));
    lfm_run_timer #(.LEN(BUS_TO))   u_bus_tmr   (.clk(clk), .rst(rst), .run(bus_run),   .hit(bus_hit));

    always_comb begin
        set_v             = '0;
        set_v.txd_stuck   = txd_hit;
        set_v.tx_rx_short = short_hit;
        set_v.hot         = active && over_temp;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_live <= 1'b0;
            was_norm <= 1'b0;
        end else begin
            bus_live <= bus_hit;
            was_norm <= (mode_e == MODE_NORM);
        end
    end

    // Clear events and the condition that every cause has gone away
    assign enter_norm  = (mode_e == MODE_NORM) && !was_norm;
    assign rx_tx_event = active && !rxd && txd;
    assign resolved    = !over_temp && txd && !(!rxd && !bus_dom) && !bus_live;
    assign clr         = (enter_norm || rx_tx_event) && resolved;

    lfm_fault_latch u_latch (.clk(clk), .rst(rst), .set(set_v), .clr(clr), .lat(lat));

    assign lf_flag = any_fault(lat) || bus_live;
    assign tx_en   = (mode_e == MODE_NORM) && !any_fault(lat);

    // R4
    bus_release_chk: assert property (@(posedge clk) disable iff (rst)
        !bus_dom |=> !bus_live);

    // R5
    hot_set_chk: assert property (@(posedge clk) disable iff (rst)
        (active && over_temp) |=> (lf_flag && !tx_en));

    // R8
    hot_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (lat.hot && over_temp) |=> lat.hot);

    // R9
    idle_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        !active |=> (lat == $past(lat)));

endmodule

// File: tb/sim_local_fail_mon.sv
module sim_local_fail_mon;
    localparam int TXD_TO   = 8;
    localparam int SHORT_TO = 4;
    localparam int BUS_TO   = 12;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] mode = 2'b00;
    logic       txd = 1'b1, rxd = 1'b1, bus_dom = 1'b0, over_temp = 1'b0;
    logic       lf_flag, tx_en;

    int    n_chk = 0, n_bad = 0;
    string phase = "R1";

    always #10 clk = ~clk;

    local_fail_mon #(.TXD_TO(TXD_TO), .SHORT_TO(SHORT_TO), .BUS_TO(BUS_TO)) u0 (
        .clk(clk), .rst(rst), .mode(mode), .txd(txd), .rxd(rxd),
        .bus_dom(bus_dom), .over_temp(over_temp), .lf_flag(lf_flag), .tx_en(tx_en));

    // Behavioural reference: run lengths as integers, one bit per latched cause
    int m_tc = 0, m_sc = 0, m_bc = 0;
    bit m_ft = 0, m_fs = 0, m_fh = 0, m_bl = 0, m_pn = 0;
    bit act, m_clr, exp_flag, exp_en;

    always @(posedge clk) begin
        if (rst) begin
            m_tc = 0; m_sc = 0; m_bc = 0;
            m_ft = 0; m_fs = 0; m_fh = 0; m_bl = 0; m_pn = 0;
        end else begin
            act   = (mode == 2'b01) || (mode == 2'b10);
            m_tc  = (act && !txd) ? m_tc + 1 : 0;
            m_sc  = (act && txd && !rxd && !bus_dom) ? m_sc + 1 : 0;
            m_bc  = (act && bus_dom) ? m_bc + 1 : 0;
            m_clr = ((mode == 2'b01 && !m_pn) || (act && !rxd && txd))
                    && !over_temp && txd && !(!rxd && !bus_dom) && !m_bl;
            m_ft  = (m_ft && !m_clr) || (m_tc >= TXD_TO);
            m_fs  = (m_fs && !m_clr) || (m_sc >= SHORT_TO);
            m_fh  = (m_fh && !m_clr) || (act && over_temp);
            m_bl  = (m_bc >= BUS_TO);
            m_pn  = (mode == 2'b01);
        end
        #5;
        if (!rst) begin
            exp_flag = m_ft || m_fs || m_fh || m_bl;
            exp_en   = (mode == 2'b01) && !(m_ft || m_fs || m_fh);
            n_chk++;
            if (lf_flag !== exp_flag || tx_en !== exp_en) begin
                n_bad++;
                $display("FAIL %s model: flag=%b en=%b expected flag=%b en=%b",
                         phase, lf_flag, tx_en, exp_flag, exp_en);
            end
        end
    end

    task automatic expect_out(input string req, input logic f, input logic e);
        n_chk++;
        if (lf_flag !== f || tx_en !== e) begin
            n_bad++;
            $display("FAIL %s: flag=%b en=%b expected flag=%b en=%b", req, lf_flag, tx_en, f, e);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(200000 * 20);
        n_bad++;
        $display("FAIL watchdog: run did not complete, expected completion");
        finish_run();
    end

    initial begin
        cyc(3);
        rst = 1'b0;
        cyc(1);
        phase = "R1"; expect_out("R1", 1'b0, 1'b0);

        phase = "R10"; mode = 2'b01; cyc(3);
        expect_out("R10", 1'b0, 1'b1);

        phase = "R11"; txd = 1'b0; cyc(TXD_TO - 1); txd = 1'b1; cyc(1);
        txd = 1'b0; cyc(TXD_TO - 1); txd = 1'b1; cyc(2);
        expect_out("R11", 1'b0, 1'b1);

        phase = "R2"; txd = 1'b0; cyc(TXD_TO);
        expect_out("R2", 1'b1, 1'b0);
        txd = 1'b1; cyc(3);
        expect_out("R2", 1'b1, 1'b0);

        phase = "R6"; mode = 2'b10; cyc(2);
        expect_out("R10", 1'b1, 1'b0);
        mode = 2'b01; cyc(1);
        expect_out("R6", 1'b0, 1'b1);

        phase = "R3"; rxd = 1'b0; cyc(SHORT_TO - 1); rxd = 1'b1; cyc(1);
        expect_out("R11", 1'b0, 1'b1);
        rxd = 1'b0; cyc(SHORT_TO); rxd = 1'b1; cyc(1);
        expect_out("R3", 1'b1, 1'b0);

        phase = "R7"; rxd = 1'b0; bus_dom = 1'b1; cyc(1);
        expect_out("R7", 1'b0, 1'b1);
        rxd = 1'b1; bus_dom = 1'b0; cyc(1);

        phase = "R4"; rxd = 1'b0; bus_dom = 1'b1; cyc(BUS_TO - 1);
        expect_out("R4", 1'b0, 1'b1);
        cyc(4);
        expect_out("R4", 1'b1, 1'b1);
        rxd = 1'b1; bus_dom = 1'b0; cyc(1);
        expect_out("R4", 1'b0, 1'b1);

        phase = "R5"; over_temp = 1'b1; cyc(1);
        expect_out("R5", 1'b1, 1'b0);
        phase = "R8"; mode = 2'b10; cyc(2); mode = 2'b01; cyc(2);
        expect_out("R8", 1'b1, 1'b0);
        rxd = 1'b0; bus_dom = 1'b1; cyc(1); rxd = 1'b1; bus_dom = 1'b0; cyc(1);
        expect_out("R8", 1'b1, 1'b0);
        over_temp = 1'b0; mode = 2'b10; cyc(2); mode = 2'b01; cyc(1);
        expect_out("R6", 1'b0, 1'b1);

        phase = "R9"; mode = 2'b00; txd = 1'b0; over_temp = 1'b1; cyc(3 * TXD_TO);
        txd = 1'b1; rxd = 1'b0; cyc(2 * SHORT_TO); rxd = 1'b1;
        mode = 2'b11; bus_dom = 1'b1; cyc(2 * BUS_TO); bus_dom = 1'b0;
        over_temp = 1'b0; cyc(1);
        expect_out("R9", 1'b0, 1'b0);
        mode = 2'b01; cyc(1);
        expect_out("R9", 1'b0, 1'b1);

        phase = "R2/R3/R4/R5/R6/R7 random";
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(0, 39) == 0) mode = 2'($urandom_range(0, 3));
            if ($urandom_range(0, 5) == 0) txd = ~txd;
            if ($urandom_range(0, 4) == 0) rxd = ($urandom_range(0, 2) != 0) ? txd : ~txd;
            if ($urandom_range(0, 9) == 0) bus_dom = ~bus_dom;
            over_temp = ($urandom_range(0, 199) == 0);
            cyc(1);
        end
        txd = 1'b1; rxd = 1'b1; bus_dom = 1'b0; over_temp = 1'b0;
        cyc(3);
        finish_run();
    end
endmodule